// File: doc/BRIEF.md
# Addressable SPI Register Slave

This block is the serial register interface of a two-channel converter front end. Several of these slaves can sit on one SPI bus and share a single chip select. Each slave has a two-bit address strapped at its pins. It takes part in a frame only when the device field of the frame's first byte, the control byte, matches that strap. After the control byte the master streams data bytes. The slave's register pointer moves on by one byte address per byte, so no further control byte is needed, and registers of 8, 16 and 24 bits can be read or written in one frame.

On writes, the pointer walks the whole map and wraps. On reads, a two-bit read-mode field in the configuration register sets the looping region: one register, a group, a type, or the whole map. The block runs on a fabric clock `clk` and samples the SPI pins through synchronizers. It needs no converter clock, so configuration can be loaded while conversion is stopped.

Top module: `spi_addr_regs`

## Requirements
- R1: The control byte is sent MSB first and is split into fields. Bits [7:6] are the device field, bits [5:1] are the byte address, and bit 0 selects the direction: 1 is a read, 0 is a write. A write frame never enables `sdo_en`.
- R2: A frame whose device field differs from `strap_id` is ignored as a whole. `sdo_en` stays 0 for that frame and no register changes.
- R3: The bus uses SPI mode 0. `sdi` is taken on rising `sck`, and `sdo` changes only after falling `sck`, MSB first. The first read bit is presented after the falling edge that follows the eighth rising edge of the control byte.
- R4: The map is byte-addressed, 0x00 to 0x0D, and a multi-byte register puts its most significant byte at its lowest address. The read-only bytes are channel 0 at 0x00–0x02, channel 1 at 0x03–0x05, and modulator flags at 0x06. The writable bytes are phase at 0x07 (8 bits), gain at 0x08 (8 bits), status at 0x09–0x0A (16 bits), configuration at 0x0B–0x0C (16 bits) and aux at 0x0D (8 bits). After reset the configuration is 0x8000 and every other writable byte is 0.
- R5: Write data continues back to back within one chip select. The pointer moves up one byte address per byte and wraps from 0x0D to 0x00. Bytes written to read-only addresses are dropped.
- R6: Read mode is configuration bits [15:14], which is bit 7:6 of byte 0x0B. Mode 00 repeats the bytes of the register that holds the pointer. The registers are 0x00–0x02, 0x03–0x05, 0x09–0x0A and 0x0B–0x0C; every other address is a register of its own.
- R7: Read mode 01 loops within a group. The groups are 0x00–0x05 and 0x07–0x0C. Address 0x06 and address 0x0D each repeat alone.
- R8: Read mode 10 loops within a type. The types are 0x00–0x05 and 0x06–0x0D. Mode 10 is the reset mode.
- R9: Read mode 11 loops over the whole map, going from 0x0D back to 0x00.
- R10: Raising `cs_n` clears the bit count and the control-byte state. A partly shifted byte is dropped without being written.
- R11: An address above 0x0D reads as 0x00 and ignores writes. After one such byte the pointer goes to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock that samples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_id | input | 2 | Strapped device address |
| ch0_sample | input | 24 | Channel 0 result, read-only at 0x00–0x02 |
| ch1_sample | input | 24 | Channel 1 result, read-only at 0x03–0x05 |
| mod_bits | input | 8 | Modulator flags, read-only at 0x06 |
| cs_n | input | 1 | Shared chip select, active low |
| sck | input | 1 | SPI clock, mode 0 |
| sdi | input | 1 | Serial data from the master |
| sdo | output | 1 | Serial data to the master |
| sdo_en | output | 1 | Output enable for the `sdo` pad driver |
| phase_val | output | 8 | Phase register |
| gain_val | output | 8 | Gain register |
| status_val | output | 16 | Status register |
| config_val | output | 16 | Configuration register; bits [15:14] are the read mode |
| aux_val | output | 8 | Aux register |

## Verification
A stale pointer shows up on `sdo` in the very next data byte, as a byte from the wrong address. Checking the second to fifth bytes of each read frame against the expected looping sequence exposes a wrong wrap point within one byte time. A wrong decode of the control byte shows within eight `sck` periods. It appears either as `sdo_en` rising on a mismatched or write frame, or as a register port changing when it should not. A control state left over after `cs_n` rises corrupts the first byte of the next frame.

// File: rtl/ars_pkg.sv
package ars_pkg;
  localparam int ADDR_W = 5;
  localparam int BYTE_W = 8;
  localparam logic [ADDR_W-1:0] MAP_LAST   = 5'd13;
  localparam logic [ADDR_W-1:0] CH1_BASE   = 5'd3;
  localparam logic [ADDR_W-1:0] MOD_ADDR   = 5'd6;
  localparam logic [ADDR_W-1:0] RW_FIRST   = 5'd7;
  localparam logic [ADDR_W-1:0] GRP_LAST   = 5'd12;
  localparam logic [ADDR_W-1:0] STAT_ADDR  = 5'd9;
  localparam logic [ADDR_W-1:0] CFG_ADDR   = 5'd11;
  localparam logic [ADDR_W-1:0] DATA_LAST  = 5'd5;

  typedef enum logic [1:0] {FS_CMD, FS_RD, FS_WR, FS_SKIP} fstate_t;

  // Next read address for a given pointer and read mode.
  function automatic logic [ADDR_W-1:0] rd_next(logic [ADDR_W-1:0] p, logic [1:0] m);
    logic [ADDR_W-1:0] lo, hi;
    lo = p;
    hi = p;
    case (m)
      2'b11: begin lo = 5'd0; hi = MAP_LAST; end
      2'b10: begin
        if (p <= DATA_LAST) begin lo = 5'd0; hi = DATA_LAST; end
        else begin lo = MOD_ADDR; hi = MAP_LAST; end
      end
      2'b01: begin
        if (p <= DATA_LAST) begin lo = 5'd0; hi = DATA_LAST; end
        else if (p >= RW_FIRST && p <= GRP_LAST) begin lo = RW_FIRST; hi = GRP_LAST; end
      end
      default: begin
        if (p < CH1_BASE) begin lo = 5'd0; hi = CH1_BASE - 5'd1; end
        else if (p <= DATA_LAST) begin lo = CH1_BASE; hi = DATA_LAST; end
        else if (p == STAT_ADDR || p == STAT_ADDR + 5'd1) begin lo = STAT_ADDR; hi = STAT_ADDR + 5'd1; end
        else if (p == CFG_ADDR || p == CFG_ADDR + 5'd1) begin lo = CFG_ADDR; hi = CFG_ADDR + 5'd1; end
      end
    endcase
    if (p > MAP_LAST) return 5'd0;
    return (p >= hi) ? lo : p + 5'd1;
  endfunction

  // Next write address: whole-map walk.
  function automatic logic [ADDR_W-1:0] wr_next(logic [ADDR_W-1:0] p);
    return (p >= MAP_LAST) ? 5'd0 : p + 5'd1;
  endfunction
endpackage

// File: rtl/ars_shifter.sv
module ars_shifter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       sdi,
  input  logic [7:0] tx_byte,
  output logic       frame_act,
  output logic       sck_rise,
  output logic       sck_fall,
  output logic       byte_stb,
  output logic [7:0] rx_byte,
  output logic [2:0] bit_cnt,
  output logic       sdo_q
);
  logic sck_s, cs_s, sdi_s, sck_d;
  logic [6:0] shreg;

  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sck_s <= 1'b0; cs_s <= 1'b1; sdi_s <= 1'b0;
        end else begin
          sck_s <= sck; cs_s <= cs_n; sdi_s <= sdi;
        end
      end
    end else begin : g_syncn
      logic [SYNC_STAGES-1:0] sck_sr, cs_sr, sdi_sr;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sck_sr <= '0; cs_sr <= '1; sdi_sr <= '0;
        end else begin
          sck_sr <= {sck_sr[SYNC_STAGES-2:0], sck};
          cs_sr  <= {cs_sr[SYNC_STAGES-2:0], cs_n};
          sdi_sr <= {sdi_sr[SYNC_STAGES-2:0], sdi};
        end
      end
      assign sck_s = sck_sr[SYNC_STAGES-1];
      assign cs_s  = cs_sr[SYNC_STAGES-1];
      assign sdi_s = sdi_sr[SYNC_STAGES-1];
    end
  endgenerate

  assign frame_act = ~cs_s;
  assign sck_rise  = frame_act & sck_s & ~sck_d;
  assign sck_fall  = frame_act & ~sck_s & sck_d;
  assign byte_stb  = sck_rise & (bit_cnt == 3'd7);
  assign rx_byte   = {shreg, sdi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d   <= 1'b0;
      shreg   <= '0;
      bit_cnt <= '0;
      sdo_q   <= 1'b0;
    end else begin
      sck_d <= sck_s;
      if (!frame_act) begin
        shreg   <= '0;
        bit_cnt <= '0;
        sdo_q   <= 1'b0;
      end else begin
        if (sck_rise) begin
          shreg   <= rx_byte[6:0];
          bit_cnt <= bit_cnt + 3'd1;
        end
        if (sck_fall) sdo_q <= tx_byte[3'd7 - bit_cnt];
      end
    end
  end
endmodule

// File: rtl/ars_frame_ctl.sv
module ars_frame_ctl
  import ars_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_act,
  input  logic              byte_stb,
  input  logic [7:0]        rx_byte,
  input  logic [1:0]        strap_id,
  input  logic [1:0]        rd_mode,
  output fstate_t           state,
  output logic [ADDR_W-1:0] ptr,
  output logic              wr_stb
);
  assign wr_stb = byte_stb && (state == FS_WR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= FS_CMD;
      ptr   <= '0;
    end else if (!frame_act) begin
      state <= FS_CMD;
    end else if (byte_stb) begin
      case (state)
        FS_CMD: begin
          if (rx_byte[7:6] == strap_id) begin
            ptr   <= rx_byte[5:1];
            state <= rx_byte[0] ? FS_RD : FS_WR;
          end else begin
            state <= FS_SKIP;
          end
        end
        FS_RD:   ptr <= rd_next(ptr, rd_mode);
        FS_WR:   ptr <= wr_next(ptr);
        default: state <= FS_SKIP;
      endcase
    end
  end
endmodule

// File: rtl/ars_regbank.sv
module ars_regbank
  import ars_pkg::*;
#(
  parameter int          SAMPLE_W  = 24,
  parameter logic [15:0] CFG_RESET = 16'h8000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] ch0_sample,
  input  logic [SAMPLE_W-1:0] ch1_sample,
  input  logic [7:0]          mod_bits,
  input  logic                wr_stb,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [7:0]          wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [7:0]          rd_byte,
  output logic [MAP_LAST:RW_FIRST][7:0] rw_q
);
  localparam int SBYTES  = SAMPLE_W / BYTE_W;
  localparam int RO_CNT  = 2 * SBYTES + 1;

  logic [RO_CNT-1:0][7:0] ro_bytes;

  generate
    for (genvar k = 0; k < SBYTES; k++) begin : g_chbytes
      assign ro_bytes[k]          = ch0_sample[SAMPLE_W-1-8*k -: 8];
      assign ro_bytes[SBYTES + k] = ch1_sample[SAMPLE_W-1-8*k -: 8];
    end
  endgenerate
  assign ro_bytes[RO_CNT-1] = mod_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = int'(RW_FIRST); a <= int'(MAP_LAST); a++) begin
        if (a == int'(CFG_ADDR))           rw_q[a] <= CFG_RESET[15:8];
        else if (a == int'(CFG_ADDR) + 1)  rw_q[a] <= CFG_RESET[7:0];
        else                               rw_q[a] <= 8'h00;
      end
    end else if (wr_stb && wr_addr >= RW_FIRST && wr_addr <= MAP_LAST) begin
      rw_q[wr_addr] <= wr_data;
    end
  end

  always_comb begin
    if (rd_addr < RW_FIRST)       rd_byte = ro_bytes[rd_addr[2:0]];
    else if (rd_addr <= MAP_LAST) rd_byte = rw_q[rd_addr];
    else                          rd_byte = 8'h00;
  end
endmodule

// File: rtl/spi_addr_regs.sv
module spi_addr_regs
  import ars_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          SAMPLE_W    = 24,
  parameter logic [15:0] CFG_RESET   = 16'h8000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          strap_id,
  input  logic [SAMPLE_W-1:0] ch0_sample,
  input  logic [SAMPLE_W-1:0] ch1_sample,
  input  logic [7:0]          mod_bits,
  input  logic                cs_n,
  input  logic                sck,
  input  logic                sdi,
  output logic                sdo,
  output logic                sdo_en,
  output logic [7:0]          phase_val,
  output logic [7:0]          gain_val,
  output logic [15:0]         status_val,
  output logic [15:0]         config_val,
  output logic [7:0]          aux_val
);
  logic              frame_act, sck_rise, sck_fall, byte_stb, wr_stb;
  logic [7:0]        rx_byte, tx_byte;
  logic [2:0]        bit_cnt;
  logic [ADDR_W-1:0] ptr;
  logic [1:0]        rd_mode;
  fstate_t           state;
  logic [MAP_LAST:RW_FIRST][7:0] rw_q;

  ars_shifter #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .tx_byte(tx_byte), .frame_act(frame_act), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .byte_stb(byte_stb), .rx_byte(rx_byte),
    .bit_cnt(bit_cnt), .sdo_q(sdo)
  );

  ars_frame_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .frame_act(frame_act), .byte_stb(byte_stb),
    .rx_byte(rx_byte), .strap_id(strap_id), .rd_mode(rd_mode),
    .state(state), .ptr(ptr), .wr_stb(wr_stb)
  );

  ars_regbank #(.SAMPLE_W(SAMPLE_W), .CFG_RESET(CFG_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .ch0_sample(ch0_sample), .ch1_sample(ch1_sample),
    .mod_bits(mod_bits), .wr_stb(wr_stb), .wr_addr(ptr), .wr_data(rx_byte),
    .rd_addr(ptr), .rd_byte(tx_byte), .rw_q(rw_q)
  );

  assign sdo_en     = frame_act && (state == FS_RD);
  assign phase_val  = rw_q[RW_FIRST];
  assign gain_val   = rw_q[RW_FIRST + 5'd1];
  assign status_val = {rw_q[STAT_ADDR], rw_q[STAT_ADDR + 5'd1]};
  assign config_val = {rw_q[CFG_ADDR], rw_q[CFG_ADDR + 5'd1]};
  assign aux_val    = rw_q[MAP_LAST];
  assign rd_mode    = config_val[15:14];
endmodule

// File: rtl/ars_chk.sv
module ars_chk
  import ars_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              frame_act,
  input logic              sck_fall,
  input logic              byte_stb,
  input logic [7:0]        rx_byte,
  input logic [1:0]        strap_id,
  input logic [2:0]        bit_cnt,
  input fstate_t           state,
  input logic [ADDR_W-1:0] ptr,
  input logic [1:0]        rd_mode,
  input logic              sdo,
  input logic              sdo_en
);
  p_idle_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_act |=> (state == FS_CMD && bit_cnt == 3'd0));

  p_quiet_mismatch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && state == FS_CMD && rx_byte[7:6] != strap_id) |=> !sdo_en);

  p_write_no_drive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && state == FS_CMD && rx_byte[0] == 1'b0) |=> !sdo_en);

  p_sdo_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_act && !sck_fall) |=> $stable(sdo));

  p_write_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && state == FS_WR && ptr == MAP_LAST) |=> ptr == 5'd0);

  p_repeat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && state == FS_RD && rd_mode == 2'b00 && ptr == RW_FIRST) |=> ptr == RW_FIRST);

  p_group_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && state == FS_RD && rd_mode == 2'b01 && ptr == GRP_LAST) |=> ptr == RW_FIRST);

  p_type_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && state == FS_RD && rd_mode == 2'b10 && ptr == DATA_LAST) |=> ptr == 5'd0);

  p_full_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && state == FS_RD && rd_mode == 2'b11 && ptr == MAP_LAST) |=> ptr == 5'd0);

  p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && state != FS_CMD && state != FS_SKIP && ptr > MAP_LAST) |=> ptr == 5'd0);
endmodule

bind spi_addr_regs ars_chk chk_i (
  .clk(clk), .rst_n(rst_n), .frame_act(frame_act), .sck_fall(sck_fall),
  .byte_stb(byte_stb), .rx_byte(rx_byte), .strap_id(strap_id),
  .bit_cnt(bit_cnt), .state(state), .ptr(ptr), .rd_mode(rd_mode),
  .sdo(sdo), .sdo_en(sdo_en)
);

// File: tb/spi_addr_regs_tb_top.sv
module spi_addr_regs_tb_top;
  localparam int HALF = 8;
  localparam logic [1:0] DEV = 2'b10;
  localparam logic [1:0] OTHER = 2'b01;

  typedef struct packed {
    logic [1:0]      mode;
    logic [4:0]      start;
    logic [0:4][4:0] seq;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{2'b11, 5'h0C, {5'h0C, 5'h0D, 5'h00, 5'h01, 5'h02}},
    '{2'b11, 5'h1F, {5'h1F, 5'h00, 5'h01, 5'h02, 5'h03}},
    '{2'b10, 5'h04, {5'h04, 5'h05, 5'h00, 5'h01, 5'h02}},
    '{2'b10, 5'h0C, {5'h0C, 5'h0D, 5'h06, 5'h07, 5'h08}},
    '{2'b10, 5'h0D, {5'h0D, 5'h06, 5'h07, 5'h08, 5'h09}},
    '{2'b01, 5'h0B, {5'h0B, 5'h0C, 5'h07, 5'h08, 5'h09}},
    '{2'b01, 5'h05, {5'h05, 5'h00, 5'h01, 5'h02, 5'h03}},
    '{2'b01, 5'h06, {5'h06, 5'h06, 5'h06, 5'h06, 5'h06}},
    '{2'b00, 5'h01, {5'h01, 5'h02, 5'h00, 5'h01, 5'h02}},
    '{2'b00, 5'h09, {5'h09, 5'h0A, 5'h09, 5'h0A, 5'h09}},
    '{2'b00, 5'h08, {5'h08, 5'h08, 5'h08, 5'h08, 5'h08}},
    '{2'b00, 5'h0D, {5'h0D, 5'h0D, 5'h0D, 5'h0D, 5'h0D}}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo, sdo_en;
  logic [23:0] ch0_sample = 24'hA1B2C3;
  logic [23:0] ch1_sample = 24'hD4E5F6;
  logic [7:0]  mod_bits = 8'h5A;
  logic [7:0]  phase_val, gain_val, aux_val;
  logic [15:0] status_val, config_val;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  bit en_seen;
  logic [7:0] tb_tx [0:15];
  logic [7:0] tb_rx [0:15];
  logic [7:0] sh [0:13];

  always #4 clk = ~clk;

  spi_addr_regs dut_i (
    .clk(clk), .rst_n(rst_n), .strap_id(DEV), .ch0_sample(ch0_sample),
    .ch1_sample(ch1_sample), .mod_bits(mod_bits), .cs_n(cs_n), .sck(sck),
    .sdi(sdi), .sdo(sdo), .sdo_en(sdo_en), .phase_val(phase_val),
    .gain_val(gain_val), .status_val(status_val), .config_val(config_val),
    .aux_val(aux_val)
  );

  function automatic logic [7:0] exp_byte(logic [4:0] a);
    return (a > 5'd13) ? 8'h00 : sh[a];
  endfunction

  function automatic logic [7:0] ctrl(logic [1:0] dev, logic [4:0] a, logic rd);
    return {dev, a, rd};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // nbytes whole bytes, then tail_bits bits of byte nbytes before cs_n rises
  task automatic spi_frame(input int nbytes, input int tail_bits);
    en_seen = 0;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b <= nbytes; b++) begin
      for (int i = 7; i >= 0; i--) begin
        if (b < nbytes || (7 - i) < tail_bits) begin
          sdi = tb_tx[b][i];
          repeat (HALF) @(negedge clk);
          tb_rx[b][i] = sdo;
          if (sdo_en) en_seen = 1;
          sck = 1'b1;
          repeat (HALF) @(negedge clk);
          sck = 1'b0;
        end
      end
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic set_mode(input logic [1:0] m);
    tb_tx[0] = ctrl(DEV, 5'h0B, 1'b0);
    tb_tx[1] = {m, 6'h15};
    spi_frame(2, 0);
    sh[11] = {m, 6'h15};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    sh[0] = 8'hA1; sh[1] = 8'hB2; sh[2] = 8'hC3;
    sh[3] = 8'hD4; sh[4] = 8'hE5; sh[5] = 8'hF6; sh[6] = 8'h5A;
    for (int a = 7; a <= 13; a++) sh[a] = 8'h00;
    sh[11] = 8'h80;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4 reset state
    check(config_val == 16'h8000 && phase_val == 8'h00 && gain_val == 8'h00 &&
          status_val == 16'h0000 && aux_val == 8'h00, "R4 reset values",
          {config_val, phase_val, aux_val}, 32'h8000_0000);
    check(sdo_en == 1'b0, "R3 sdo_en idle", sdo_en, 0);

    // R5/R1: back-to-back write of phase..status, write frame never drives
    tb_tx[0] = ctrl(DEV, 5'h07, 1'b0);
    tb_tx[1] = 8'h11; tb_tx[2] = 8'h22; tb_tx[3] = 8'h33; tb_tx[4] = 8'h44;
    spi_frame(5, 0);
    sh[7] = 8'h11; sh[8] = 8'h22; sh[9] = 8'h33; sh[10] = 8'h44;
    check(phase_val == 8'h11 && gain_val == 8'h22 && status_val == 16'h3344,
          "R5 streamed write", {phase_val, gain_val, status_val}, 32'h1122_3344);
    check(!en_seen, "R1 write frame leaves sdo_en low", en_seen, 0);

    // R5 write wrap 0x0D -> 0x00, read-only bytes ignore writes
    tb_tx[0] = ctrl(DEV, 5'h0C, 1'b0);
    tb_tx[1] = 8'h3C; tb_tx[2] = 8'h9D; tb_tx[3] = 8'hFF; tb_tx[4] = 8'hEE;
    spi_frame(5, 0);
    sh[12] = 8'h3C; sh[13] = 8'h9D;
    check(aux_val == 8'h9D && config_val == 16'h803C, "R5 write into 0x0C..0x0D",
          {aux_val, config_val}, {8'h9D, 16'h803C});
    tb_tx[0] = ctrl(DEV, 5'h00, 1'b1);
    spi_frame(3, 0);
    check(tb_rx[1] == 8'hA1 && tb_rx[2] == 8'hB2 && en_seen, "R5 wrap hit read-only 0x00",
          {tb_rx[1], tb_rx[2]}, 16'hA1B2);

    // R2 mismatched device: write and read both ignored
    tb_tx[0] = ctrl(OTHER, 5'h07, 1'b0);
    tb_tx[1] = 8'hE7;
    spi_frame(2, 0);
    check(phase_val == 8'h11, "R2 mismatched write dropped", phase_val, 8'h11);
    tb_tx[0] = ctrl(OTHER, 5'h07, 1'b1);
    tb_tx[1] = 8'h00; tb_tx[2] = 8'h00;
    spi_frame(3, 0);
    check(!en_seen, "R2 mismatched read keeps sdo_en low", en_seen, 0);

    // R10 partial byte aborted, next frame decodes cleanly
    tb_tx[0] = ctrl(DEV, 5'h07, 1'b0);
    tb_tx[1] = 8'hC5;
    spi_frame(1, 4);
    check(phase_val == 8'h11, "R10 partial byte not committed", phase_val, 8'h11);
    tb_tx[0] = ctrl(DEV, 5'h07, 1'b0);
    tb_tx[1] = 8'h77;
    spi_frame(2, 0);
    sh[7] = 8'h77;
    check(phase_val == 8'h77, "R10 clean frame after abort", phase_val, 8'h77);

    // R11 unmapped writes change nothing
    tb_tx[0] = ctrl(DEV, 5'h0E, 1'b0);
    tb_tx[1] = 8'h55; tb_tx[2] = 8'h66;
    spi_frame(3, 0);
    check(phase_val == 8'h77 && gain_val == 8'h22 && aux_val == 8'h9D,
          "R11 unmapped write dropped", {phase_val, gain_val, aux_val}, {8'h77, 8'h22, 8'h9D});

    // R3/R6..R9/R11: read-mode table
    for (int i = 0; i < 12; i++) begin
      logic [39:0] got, exp;
      set_mode(VECS[i].mode);
      tb_tx[0] = ctrl(DEV, VECS[i].start, 1'b1);
      for (int k = 1; k <= 5; k++) tb_tx[k] = 8'h00;
      spi_frame(6, 0);
      for (int k = 0; k < 5; k++) begin
        got[39-8*k -: 8] = tb_rx[k+1];
        exp[39-8*k -: 8] = exp_byte(VECS[i].seq[k]);
      end
      case (VECS[i].mode)
        2'b00: check(got == exp && en_seen, "R6 repeat-register read (R3 order)", got[31:0], exp[31:0]);
        2'b01: check(got == exp && en_seen, "R7 group loop read (R3 order)", got[31:0], exp[31:0]);
        2'b10: check(got == exp && en_seen, "R8 type loop read (R3 order)", got[31:0], exp[31:0]);
        default: check(got == exp && en_seen, "R9 full-map read / R11 unmapped", got[31:0], exp[31:0]);
      endcase
      check(config_val[15:14] == VECS[i].mode, "R6 mode field in config[15:14]",
            config_val[15:14], VECS[i].mode);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule